// File: doc/BRIEF.md
# Queue-Driven Event Timing Controller

This block separates a part of the chip that issues work at irregular speed from a part that must act on an exact cycle grid. Upstream logic loads two kinds of queue ahead of time. A timing queue holds time points, each written as a gap since the point before it and tagged with a label. A set of event queues holds operations, each tagged with the label of the time point at which it must be released.

Once a start command or a rising edge on an external trigger arrives, the controller runs its own cycle counter. When the gap of the timing-queue head has passed, it pops that head and broadcasts its label. In that same cycle, every event queue whose head carries the broadcast label pops the head. The popped operations appear on registered outputs one cycle later, together with the broadcast label.

If the timing queue runs dry while the counter is running, the controller stops and raises a sticky flag. A stop command halts the counter at any time and leaves the queue contents in place.

Top module: `evt_timing_ctrl`

## Requirements
- R1: After reset, `running`, `underflow`, `tick_valid`, every `fire_valid` bit, `tp_full` and every `ev_full` bit are 0, and every queue is empty.
- R2: Let a start command be sampled at clock edge E0 while the controller is idle. `running` is 1 after E0. The first timing-queue entry, with gap G, produces a one-cycle `tick_valid` pulse carrying its label, visible after edge E0+G+1. Each later entry with gap G produces its pulse G+1 edges after the previous pulse.
- R3: A rising edge of `ext_trig` starts the controller with the same timing as a start command. Holding `ext_trig` high does not start the controller again after it has gone idle.
- R4: On a broadcast, an event queue whose head label equals the broadcast label pops that head. It shows `fire_valid`=1 and the entry's operation on `fire_op` on the same edge as `tick_valid`, one cycle after the broadcast.
- R5: An event queue whose head label differs from the broadcast label emits nothing and keeps its head. That entry fires later, on the broadcast of its own label.
- R6: All event queues whose heads match one broadcast fire on the same cycle.
- R7: A gap of 0 is legal and gives a `tick_valid` pulse on the edge right after the previous one, so pulses can come back to back.
- R8: If the timing queue is empty while running, the controller drops `running` and sets `underflow` on the next edge, which is the edge after the last pulse. `underflow` then stays 1 until the next start clears it.
- R9: `stop_cmd` makes `running` 0 at the next edge and suppresses any broadcast in that cycle. No further pulses occur until a new start. A new start counts the remaining head gap from zero, and `underflow` stays 0.
- R10: Each queue holds a fixed number of entries (16 by default). Its full flag is 1 when it holds that many. A push into a full queue is ignored and leaves the contents unchanged.
- R11: A start command or trigger edge that arrives while the controller is running has no effect on the timing of the pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_cmd | input | 1 | Start the deterministic counter when idle |
| ext_trig | input | 1 | External start; a rising edge acts as a start |
| stop_cmd | input | 1 | Halt the counter |
| tp_push | input | 1 | Write one time point into the timing queue |
| tp_interval | input | INTV_W | Gap, in cycles, after the previous time point |
| tp_label | input | LABEL_W | Label of the time point being written |
| tp_full | output | 1 | Timing queue is full |
| ev_push | input | NUM_EQ | Per-queue write strobe for events |
| ev_op | input | NUM_EQ x OP_W | Operation code for each event queue |
| ev_label | input | NUM_EQ x LABEL_W | Time-point label for each event written |
| ev_full | output | NUM_EQ | Per-queue full flags |
| running | output | 1 | Deterministic counter is active |
| underflow | output | 1 | Sticky: timing queue ran dry while running |
| tick_valid | output | 1 | A time-point label was broadcast (registered) |
| tick_label | output | LABEL_W | The broadcast label |
| fire_valid | output | NUM_EQ | Per-queue released-event strobe |
| fire_op | output | NUM_EQ x OP_W | Per-queue released operation |

## Verification
A directed mix of gaps, including a zero gap, shows that each pulse sits exactly gap+1 edges after the one before it. In that mix, two queues share a label and a third holds a label that is only broadcast in a later run, which separates firing on a label match from firing in order. Further directed cases cover a trigger held high across a stop, a fill beyond capacity followed by a run that shows the extra entries were dropped, and a redundant start in the middle of a run. Seeded random sequences of gaps and sparse label subsets per queue are then compared, cycle by cycle, against an expected timeline that the bench builds from the gap sums.

// File: rtl/evt_timing_pkg.sv
package evt_timing_pkg;

    parameter int unsigned INTV_W  = 12;
    parameter int unsigned LABEL_W = 8;
    parameter int unsigned OP_W    = 10;

    typedef logic [INTV_W-1:0]  intv_t;
    typedef logic [LABEL_W-1:0] label_t;
    typedef logic [OP_W-1:0]    op_t;

    // one time point: gap since the previous point plus its tag
    typedef struct packed {
        intv_t  gap;
        label_t tag;
    } tpoint_t;

    // one event: operation plus the tag of the point it waits for
    typedef struct packed {
        op_t    op;
        label_t tag;
    } event_t;

    localparam int unsigned TPOINT_W = $bits(tpoint_t);
    localparam int unsigned EVENT_W  = $bits(event_t);

    typedef enum logic {
        CTRL_IDLE = 1'b0,
        CTRL_RUN  = 1'b1
    } ctrl_state_t;

    function automatic logic tag_hit(input label_t head_tag, input label_t bcast_tag);
        return head_tag == bcast_tag;
    endfunction

endpackage

// File: rtl/evt_fifo.sv
module evt_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R10: occupancy never passes the capacity
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R10: a push into a full queue without a pop leaves it full and the head unchanged
    p_full_push_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (full && $stable(dout)));

endmodule

// File: rtl/evt_time_ctrl.sv
module evt_time_ctrl
    import evt_timing_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_cmd,
    input  logic  ext_trig,
    input  logic  stop_cmd,
    input  logic  tq_empty,
    input  intv_t head_gap,
    output logic  hit,
    output logic  running,
    output logic  underflow
);
    ctrl_state_t state_q;
    intv_t       cnt_q;
    logic        trig_q;
    logic        go;

    assign go      = start_cmd | (ext_trig & ~trig_q);
    assign running = (state_q == CTRL_RUN);
    assign hit     = running & ~stop_cmd & ~tq_empty & (cnt_q == head_gap);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= CTRL_IDLE;
            cnt_q     <= '0;
            trig_q    <= 1'b0;
            underflow <= 1'b0;
        end else begin
            trig_q <= ext_trig;
            if (stop_cmd) begin
                state_q <= CTRL_IDLE;
            end else begin
                case (state_q)
                    CTRL_IDLE: begin
                        if (go) begin
                            state_q   <= CTRL_RUN;
                            cnt_q     <= '0;
                            underflow <= 1'b0;
                        end
                    end
                    CTRL_RUN: begin
                        if (tq_empty) begin
                            state_q   <= CTRL_IDLE;
                            underflow <= 1'b1;
                        end else if (hit) begin
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + intv_t'(1);
                        end
                    end
                    default: state_q <= CTRL_IDLE;
                endcase
            end
        end
    end

    // R8: the sticky flag is only ever seen with the counter halted
    p_underflow_idle_r8: assert property (@(posedge clk) disable iff (rst)
        underflow |-> !running);

    // R2: the running count never passes the gap of the current head
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (running && !tq_empty) |-> (cnt_q <= head_gap));

    // R9: a stop command always halts the counter at the next edge
    p_stop_halts_r9: assert property (@(posedge clk) disable iff (rst)
        stop_cmd |=> !running);

endmodule

// File: rtl/evt_fire_lane.sv
module evt_fire_lane
    import evt_timing_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hit,
    input  label_t bcast_tag,
    input  event_t head,
    input  logic   empty,
    output logic   pop,
    output logic   fire_valid,
    output op_t    fire_op
);
    assign pop = hit & ~empty & tag_hit(head.tag, bcast_tag);

    always_ff @(posedge clk) begin
        if (rst) begin
            fire_valid <= 1'b0;
            fire_op    <= '0;
        end else begin
            fire_valid <= pop;
            if (pop) fire_op <= head.op;
        end
    end

    // R5: a non-matching head survives the broadcast untouched
    p_hold_unmatched_r5: assert property (@(posedge clk) disable iff (rst)
        (hit && !empty && (head.tag != bcast_tag)) |=> (!empty && $stable(head)));

endmodule

// File: rtl/evt_timing_ctrl.sv
module evt_timing_ctrl
    import evt_timing_pkg::*;
#(
    parameter int unsigned NUM_EQ   = 4,
    parameter int unsigned EQ_DEPTH = 16,
    parameter int unsigned TQ_DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start_cmd,
    input  logic                           ext_trig,
    input  logic                           stop_cmd,
    input  logic                           tp_push,
    input  logic [INTV_W-1:0]              tp_interval,
    input  logic [LABEL_W-1:0]             tp_label,
    output logic                           tp_full,
    input  logic [NUM_EQ-1:0]              ev_push,
    input  logic [NUM_EQ-1:0][OP_W-1:0]    ev_op,
    input  logic [NUM_EQ-1:0][LABEL_W-1:0] ev_label,
    output logic [NUM_EQ-1:0]              ev_full,
    output logic                           running,
    output logic                           underflow,
    output logic                           tick_valid,
    output logic [LABEL_W-1:0]             tick_label,
    output logic [NUM_EQ-1:0]              fire_valid,
    output logic [NUM_EQ-1:0][OP_W-1:0]    fire_op
);
    tpoint_t               tq_in, tq_head;
    logic [TPOINT_W-1:0]   tq_head_raw;
    logic                  tq_empty;
    logic                  hit;

    assign tq_in   = '{gap: tp_interval, tag: tp_label};
    assign tq_head = tpoint_t'(tq_head_raw);

    evt_fifo #(.W(TPOINT_W), .DEPTH(TQ_DEPTH)) u_tq (
        .clk   (clk),
        .rst   (rst),
        .push  (tp_push),
        .din   (tq_in),
        .pop   (hit),
        .dout  (tq_head_raw),
        .empty (tq_empty),
        .full  (tp_full)
    );

    evt_time_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_cmd (start_cmd),
        .ext_trig  (ext_trig),
        .stop_cmd  (stop_cmd),
        .tq_empty  (tq_empty),
        .head_gap  (tq_head.gap),
        .hit       (hit),
        .running   (running),
        .underflow (underflow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_valid <= 1'b0;
            tick_label <= '0;
        end else begin
            tick_valid <= hit;
            if (hit) tick_label <= tq_head.tag;
        end
    end

    for (genvar g = 0; g < NUM_EQ; g++) begin : g_lane
        event_t             ev_in, ev_head;
        logic [EVENT_W-1:0] ev_head_raw;
        logic               ev_empty;
        logic               ev_pop;

        assign ev_in   = '{op: ev_op[g], tag: ev_label[g]};
        assign ev_head = event_t'(ev_head_raw);

        evt_fifo #(.W(EVENT_W), .DEPTH(EQ_DEPTH)) u_eq (
            .clk   (clk),
            .rst   (rst),
            .push  (ev_push[g]),
            .din   (ev_in),
            .pop   (ev_pop),
            .dout  (ev_head_raw),
            .empty (ev_empty),
            .full  (ev_full[g])
        );

        evt_fire_lane u_lane (
            .clk        (clk),
            .rst        (rst),
            .hit        (hit),
            .bcast_tag  (tq_head.tag),
            .head       (ev_head),
            .empty      (ev_empty),
            .pop        (ev_pop),
            .fire_valid (fire_valid[g]),
            .fire_op    (fire_op[g])
        );
    end

    // R4: a released event is always accompanied by the label broadcast
    p_fire_with_tick_r4: assert property (@(posedge clk) disable iff (rst)
        (|fire_valid) |-> tick_valid);

    // R8: the flag rises only as the counter halts
    p_underflow_halt_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(underflow) |-> $fell(running));

endmodule

// File: tb/evt_timing_ctrl_tb_top.sv
`timescale 1ns/1ps
module evt_timing_ctrl_tb_top;
    import evt_timing_pkg::*;

    localparam int NQ = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_cmd = 1'b0, ext_trig = 1'b0, stop_cmd = 1'b0;
    logic tp_push = 1'b0;
    logic [INTV_W-1:0] tp_interval = '0;
    logic [LABEL_W-1:0] tp_label = '0;
    logic tp_full;
    logic [NQ-1:0] ev_push = '0;
    logic [NQ-1:0][OP_W-1:0] ev_op = '0;
    logic [NQ-1:0][LABEL_W-1:0] ev_label = '0;
    logic [NQ-1:0] ev_full;
    logic running, underflow, tick_valid;
    logic [LABEL_W-1:0] tick_label;
    logic [NQ-1:0] fire_valid;
    logic [NQ-1:0][OP_W-1:0] fire_op;

    evt_timing_ctrl #(.NUM_EQ(NQ), .EQ_DEPTH(16), .TQ_DEPTH(16)) dut_i (
        .clk(clk), .rst(rst), .start_cmd(start_cmd), .ext_trig(ext_trig),
        .stop_cmd(stop_cmd), .tp_push(tp_push), .tp_interval(tp_interval),
        .tp_label(tp_label), .tp_full(tp_full), .ev_push(ev_push), .ev_op(ev_op),
        .ev_label(ev_label), .ev_full(ev_full), .running(running),
        .underflow(underflow), .tick_valid(tick_valid), .tick_label(tick_label),
        .fire_valid(fire_valid), .fire_op(fire_op)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // expected-value model of the queue contents
    int m_tq_gap[64], m_tq_lb[64];
    int tq_wr, tq_rd;
    int m_eq_op[NQ][64], m_eq_lb[NQ][64];
    int eq_wr[NQ], eq_rd[NQ];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply_reset();
        rst = 1'b1;
        start_cmd = 0; ext_trig = 0; stop_cmd = 0; tp_push = 0; ev_push = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        tq_wr = 0; tq_rd = 0;
        for (int q = 0; q < NQ; q++) begin eq_wr[q] = 0; eq_rd[q] = 0; end
    endtask

    task automatic push_tp(input int gap, input int lb);
        @(negedge clk);
        tp_push = 1; tp_interval = INTV_W'(gap); tp_label = LABEL_W'(lb);
        if (tq_wr - tq_rd < 16) begin
            m_tq_gap[tq_wr % 64] = gap; m_tq_lb[tq_wr % 64] = lb; tq_wr++;
        end
        @(posedge clk); #1 tp_push = 0;
    endtask

    task automatic push_ev(input int q, input int op, input int lb);
        @(negedge clk);
        ev_push[q] = 1; ev_op[q] = OP_W'(op); ev_label[q] = LABEL_W'(lb);
        if (eq_wr[q] - eq_rd[q] < 16) begin
            m_eq_op[q][eq_wr[q] % 64] = op; m_eq_lb[q][eq_wr[q] % 64] = lb; eq_wr[q]++;
        end
        @(posedge clk); #1 ev_push[q] = 0;
    endtask

    // builds the expected timeline from gap sums, starts, and compares per edge
    task automatic run_and_check(input bit via_trig, input int poke_n,
                                 input string tick_req, input string fire_req);
        int exp_tick[128];
        int exp_fire[NQ][128];
        int p[NQ];
        int t;
        int tlast;
        for (int i = 0; i < 128; i++) begin
            exp_tick[i] = -1;
            for (int q = 0; q < NQ; q++) exp_fire[q][i] = -1;
        end
        for (int q = 0; q < NQ; q++) p[q] = eq_rd[q];
        t = 0;
        for (int k = tq_rd; k < tq_wr; k++) begin
            t += m_tq_gap[k % 64] + 1;
            exp_tick[t] = m_tq_lb[k % 64];
            for (int q = 0; q < NQ; q++)
                if (p[q] < eq_wr[q] && m_eq_lb[q][p[q] % 64] == m_tq_lb[k % 64]) begin
                    exp_fire[q][t] = m_eq_op[q][p[q] % 64];
                    p[q]++;
                end
        end
        tlast = t;
        tq_rd = tq_wr;
        for (int q = 0; q < NQ; q++) eq_rd[q] = p[q];

        @(negedge clk);
        if (via_trig) ext_trig = 1; else start_cmd = 1;
        @(posedge clk); #1;
        start_cmd = 0; ext_trig = 0;
        chk(running == 1'b1, via_trig ? "R3" : "R2", "running after start", running, 1);
        chk(underflow == 1'b0, "R8", "underflow cleared by start", underflow, 0);

        for (int n = 1; n <= tlast + 1; n++) begin
            start_cmd = (n == poke_n && n < tlast);   // R11: redundant start while running
            @(posedge clk); #1;
            start_cmd = 0;
            if (n <= tlast) begin
                chk(tick_valid == (exp_tick[n] >= 0), tick_req, "tick_valid",
                    tick_valid, exp_tick[n] >= 0);
                if (exp_tick[n] >= 0)
                    chk(int'(tick_label) == exp_tick[n], tick_req, "tick_label",
                        tick_label, exp_tick[n]);
                for (int q = 0; q < NQ; q++) begin
                    chk(fire_valid[q] == (exp_fire[q][n] >= 0), fire_req, "fire_valid",
                        fire_valid[q], exp_fire[q][n] >= 0);
                    if (exp_fire[q][n] >= 0)
                        chk(int'(fire_op[q]) == exp_fire[q][n], fire_req, "fire_op",
                            fire_op[q], exp_fire[q][n]);
                end
            end else begin
                chk(underflow == 1'b1, "R8", "underflow after last point", underflow, 1);
                chk(running == 1'b0, "R8", "running after underflow", running, 0);
                chk(tick_valid == 1'b0, "R8", "tick after drain", tick_valid, 0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        apply_reset();
        // R1: reset state
        chk(running == 0, "R1", "running", running, 0);
        chk(underflow == 0, "R1", "underflow", underflow, 0);
        chk(tick_valid == 0, "R1", "tick_valid", tick_valid, 0);
        chk(fire_valid == '0, "R1", "fire_valid", fire_valid, 0);
        chk(tp_full == 0, "R1", "tp_full", tp_full, 0);
        chk(ev_full == '0, "R1", "ev_full", ev_full, 0);

        // directed: zero gap, shared labels (R6, R7), one entry waiting for a later label (R5)
        push_tp(2, 5); push_tp(0, 6); push_tp(3, 7);
        push_ev(0, 101, 5); push_ev(0, 102, 7);
        push_ev(1, 303, 9);
        push_ev(2, 202, 6);
        push_ev(3, 404, 5);
        run_and_check(0, -1, "R7", "R6");
        push_tp(1, 9);
        run_and_check(0, -1, "R2", "R5");

        // trigger start, stop, held trigger (R3, R9)
        apply_reset();
        push_tp(3, 1); push_tp(3, 2); push_tp(2, 3);
        @(negedge clk); ext_trig = 1;
        @(posedge clk); #1;
        chk(running == 1, "R3", "running after trigger edge", running, 1);
        for (int n = 1; n <= 4; n++) begin
            @(posedge clk); #1;
            chk(tick_valid == (n == 4), "R3", "tick_valid", tick_valid, n == 4);
            if (n == 4) chk(tick_label == 1, "R3", "tick_label", tick_label, 1);
        end
        stop_cmd = 1;
        @(posedge clk); #1;
        stop_cmd = 0;
        chk(running == 0, "R9", "running after stop", running, 0);
        chk(underflow == 0, "R9", "underflow after stop", underflow, 0);
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1;
            chk(tick_valid == 0 && running == 0, "R3", "held trigger restarts",
                {tick_valid, running}, 0);
        end
        ext_trig = 0;
        tq_rd = 1;
        run_and_check(0, -1, "R9", "R4");

        // capacity (R10)
        apply_reset();
        for (int k = 0; k < 16; k++) push_tp(0, k + 1);
        chk(tp_full == 1, "R10", "tp_full", tp_full, 1);
        push_tp(0, 99);
        for (int k = 0; k < 16; k++) push_ev(0, 100 + k, k + 1);
        chk(ev_full[0] == 1, "R10", "ev_full", ev_full[0], 1);
        push_ev(0, 777, 17);
        run_and_check(0, -1, "R10", "R10");
        chk(tp_full == 0, "R10", "tp_full after drain", tp_full, 0);
        push_tp(0, 17);
        run_and_check(0, -1, "R10", "R10");

        // seeded random sequences with a redundant start inside each run (R11)
        for (int it = 0; it < 8; it++) begin
            int k_n;
            apply_reset();
            k_n = 1 + int'($urandom % 8);
            for (int k = 0; k < k_n; k++) push_tp(int'($urandom % 7), 10 + 3 * k);
            for (int q = 0; q < NQ; q++) begin
                for (int k = 0; k < k_n; k++)
                    if ($urandom % 2 == 1) push_ev(q, int'($urandom % 1024), 10 + 3 * k);
                if ($urandom % 4 == 0) push_ev(q, 5, 250);
            end
            run_and_check(it % 2 == 1, 1 + int'($urandom % 6), "R11", "R4");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule